// File: doc/BRIEF.md
# Two-Wire Bus Condition and Stuck-Line Monitor

This block watches an already synchronized clock line and data line of a two-wire serial bus. It compares only the values presented on cycles where the sample enable is high, and it compares each such sample with the one before it. A falling data line while the clock line stays high is taken as a START condition. A rising data line while the clock line stays high is taken as a STOP condition. From these it keeps a bus-occupied flag. It also keeps two sticky event flags, one for START and one for STOP. The event flags feed a single interrupt output through a two-bit enable mask.

Beside the condition logic sits a stuck-bus detector. It runs a 4-bit counter that advances on every enabled sample taken while the clock line is high. The counter saturates at 15, and every clock-line falling edge returns it to zero. The hang output rises when the counter is already full at a sample that finds the data line low. It drops without any software action on the next clock-line falling edge or on a STOP.

The bus tracker has two states. BUS_FREE moves to BUS_HELD on a START. BUS_HELD moves back to BUS_FREE on a STOP, and it stays in BUS_HELD on a repeated START. The hang watcher has two states. HANG_CLEAR moves to HANG_SET when the counter is full, the clock line is high and the data line is low. HANG_SET moves back to HANG_CLEAR on a clock-line fall or a STOP. A high level on the disable input sends both machines to their first state, and clears the counter and the event flags.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, busy, start_flag, stop_flag, hang and irq are all 0. The previous sample is taken as both lines high.
- R2: A START is detected when two consecutive enabled samples show the clock line high in both and the data line going from 1 to 0. On the clock edge that takes the second sample, busy and start_flag become 1.
- R3: A STOP is detected when two consecutive enabled samples show the clock line high in both and the data line going from 0 to 1. On that edge, busy becomes 0 and stop_flag becomes 1.
- R4: A repeated START, seen while busy is 1, sets start_flag again and leaves busy at 1.
- R5: start_flag and stop_flag are sticky. A clr_start or clr_stop pulse on a cycle clears only its own flag. If a new event arrives on the same edge as the clear, the set wins.
- R6: Line changes on cycles where samp_en is 0 have no effect. Data-line changes while the clock line is low are neither START nor STOP.
- R7: irq is (start_flag AND irq_en[0]) OR (stop_flag AND irq_en[1]).
- R8: The hang counter rises by one on each enabled sample with the clock line high, and it stops at 15. hang becomes 1 on an enabled sample that finds the counter at 15, the clock line high and the data line low. After a clock-line fall, this is the 16th consecutive high-clock sample or any later one.
- R9: An enabled sample that shows the clock line falling (1 then 0) resets the counter to 0 and clears hang. A STOP also clears hang.
- R10: While mon_off is 1, busy, start_flag, stop_flag, hang and the counter are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_off | input | 1 | Forces the monitor to its idle state |
| samp_en | input | 1 | Sample-clock enable; line values are taken only when high |
| scl_s | input | 1 | Synchronized clock-line level |
| sda_s | input | 1 | Synchronized data-line level |
| clr_start | input | 1 | Write-1 clear for start_flag |
| clr_stop | input | 1 | Write-1 clear for stop_flag |
| irq_en | input | 2 | Interrupt mask: bit 0 START, bit 1 STOP |
| busy | output | 1 | Bus occupied between START and STOP |
| start_flag | output | 1 | Sticky START / repeated START seen |
| stop_flag | output | 1 | Sticky STOP seen |
| hang | output | 1 | Data line held low through a long clock-high period |
| irq | output | 1 | Masked OR of the event flags |

## Verification
A long pseudo-random walk over every one of the sixteen transitions between consecutive line-pair samples separates true START and STOP edges from data changes made under a low clock line. Along the walk, clears, mask values and disable pulses are mixed in, and the results are compared with an arithmetic model of the flags and the counter. Directed runs hold the clock high with the data line low for exactly 15 and then 16 samples, which separates a correct overflow point from an off-by-one error. A run that saturates the counter with the data line high and then drops the data line shows saturation apart from wrap-around. Line wiggles with the enable low, and a clear that lands on the same edge as a new event, show the gating and the set-over-clear priority.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } bus_st_t;

    typedef enum logic {
        HANG_CLEAR = 1'b0,
        HANG_SET   = 1'b1
    } hang_st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_fall;
    } line_ev_t;

endpackage

// File: rtl/bw_line_edges.sv
module bw_line_edges
    import bw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     samp_en,
    input  logic     scl_s,
    input  logic     sda_s,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (samp_en) begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start    = samp_en & scl_q & scl_s &  sda_q & ~sda_s;
        ev.stop     = samp_en & scl_q & scl_s & ~sda_q &  sda_s;
        ev.scl_fall = samp_en & scl_q & ~scl_s;
    end

    // R6
    cond_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |-> !(ev.start || ev.stop || ev.scl_fall));

endmodule

// File: rtl/bw_bus_tracker.sv
module bw_bus_tracker
    import bw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dis,
    input  line_ev_t ev,
    input  logic     clr_start,
    input  logic     clr_stop,
    output logic     busy,
    output logic     start_flag,
    output logic     stop_flag
);
    bus_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_FREE: if (ev.start) st_d = BUS_HELD;
            BUS_HELD: if (ev.stop)  st_d = BUS_FREE;
            default:  st_d = BUS_FREE;
        endcase
        if (dis) st_d = BUS_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else if (dis) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            start_flag <= ev.start | (start_flag & ~clr_start);
            stop_flag  <= ev.stop  | (stop_flag  & ~clr_stop);
        end
    end

    assign busy = (st_q == BUS_HELD);

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.start && !dis) |=> (busy && start_flag));
    // R3
    stop_frees_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.stop && !dis) |=> (!busy && stop_flag));
    // R5
    start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && !clr_start && !dis) |=> start_flag);
    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (!busy && !start_flag && !stop_flag));

endmodule

// File: rtl/bw_hang_watch.sv
module bw_hang_watch
    import bw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dis,
    input  logic     samp_en,
    input  logic     scl_s,
    input  logic     sda_s,
    input  line_ev_t ev,
    output logic     hang
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    hang_st_t         st_q, st_d;
    logic             full_low;

    assign full_low = samp_en & scl_s & ~sda_s & (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (dis || ev.scl_fall)   cnt_q <= '0;
        else if (samp_en && scl_s && cnt_q != CNT_MAX)
                                       cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HANG_CLEAR: if (full_low) st_d = HANG_SET;
            HANG_SET:   if (ev.scl_fall || ev.stop) st_d = HANG_CLEAR;
            default:    st_d = HANG_CLEAR;
        endcase
        if (dis) st_d = HANG_CLEAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HANG_CLEAR;
        else        st_q <= st_d;
    end

    assign hang = (st_q == HANG_SET);

    // R8
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !dis && !ev.scl_fall) |=> (cnt_q == CNT_MAX));
    // R8
    hang_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hang) |-> $past(samp_en && scl_s && !sda_s));
    // R9
    hang_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev.scl_fall || ev.stop) && !dis) |=> (!hang && (cnt_q == '0 || !ev.scl_fall)));

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import bw_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int NUM_EV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_off,
    input  logic              samp_en,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              clr_start,
    input  logic              clr_stop,
    input  logic [NUM_EV-1:0] irq_en,
    output logic              busy,
    output logic              start_flag,
    output logic              stop_flag,
    output logic              hang,
    output logic              irq
);
    line_ev_t          ev;
    logic [NUM_EV-1:0] ev_flags;
    logic [NUM_EV-1:0] masked;

    bw_line_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .ev      (ev)
    );

    bw_bus_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis        (mon_off),
        .ev         (ev),
        .clr_start  (clr_start),
        .clr_stop   (clr_stop),
        .busy       (busy),
        .start_flag (start_flag),
        .stop_flag  (stop_flag)
    );

    bw_hang_watch #(.CNT_W(CNT_W)) u_hang (
        .clk     (clk),
        .rst_n   (rst_n),
        .dis     (mon_off),
        .samp_en (samp_en),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .ev      (ev),
        .hang    (hang)
    );

    assign ev_flags = {stop_flag, start_flag};

    for (genvar g = 0; g < NUM_EV; g++) begin : g_mask
        assign masked[g] = ev_flags[g] & irq_en[g];
    end

    assign irq = |masked;

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (start_flag || stop_flag));

endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_off = 1'b0;
    logic       samp_en = 1'b0;
    logic       scl_s = 1'b1;
    logic       sda_s = 1'b1;
    logic       clr_start = 1'b0;
    logic       clr_stop = 1'b0;
    logic [1:0] irq_en = 2'b00;
    logic       busy, start_flag, stop_flag, hang, irq;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    // model state
    logic       m_ps = 1'b1, m_pd = 1'b1;
    logic       m_busy = 1'b0, m_sf = 1'b0, m_pf = 1'b0, m_hang = 1'b0;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    i2c_bus_watch i_i2c_bus_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_off    (mon_off),
        .samp_en    (samp_en),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .clr_start  (clr_start),
        .clr_stop   (clr_stop),
        .irq_en     (irq_en),
        .busy       (busy),
        .start_flag (start_flag),
        .stop_flag  (stop_flag),
        .hang       (hang),
        .irq        (irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic compare(input string tag);
        logic [4:0] act, exp;
        logic       m_irq;
        m_irq = (m_sf & irq_en[0]) | (m_pf & irq_en[1]);
        act = {busy, start_flag, stop_flag, hang, irq};
        exp = {m_busy, m_sf, m_pf, m_hang, m_irq};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {busy,start,stop,hang,irq} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic d, input logic cs, input logic cp, input string tag);
        logic st, sp, fl;
        @(negedge clk);
        scl_s = s; sda_s = d; clr_start = cs; clr_stop = cp; samp_en = 1'b1;
        st = m_ps & s & m_pd & ~d;
        sp = m_ps & s & ~m_pd & d;
        fl = m_ps & ~s;
        if (mon_off) begin
            m_busy = 0; m_sf = 0; m_pf = 0; m_hang = 0; m_cnt = 0;
        end else begin
            if (st) m_busy = 1; else if (sp) m_busy = 0;
            m_sf = st | (m_sf & ~cs);
            m_pf = sp | (m_pf & ~cp);
            if (fl | sp) m_hang = 0;
            else if (s && !d && m_cnt == 15) m_hang = 1;
            if (fl) m_cnt = 0;
            else if (s && m_cnt < 15) m_cnt = m_cnt + 1;
        end
        m_ps = s; m_pd = d;
        @(negedge clk);
        samp_en = 1'b0; clr_start = 1'b0; clr_stop = 1'b0;
        compare(tag);
    endtask

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset");

        // R2 start, R4 repeated start, R3 stop
        irq_en = 2'b11;
        step(1, 0, 0, 0, "R2 start");
        step(0, 0, 0, 0, "R9 scl fall");
        step(0, 1, 0, 0, "R6 sda rise under low scl");
        step(1, 1, 0, 0, "R6 scl rise");
        step(1, 0, 0, 0, "R4 repeated start");
        step(1, 0, 1, 0, "R5 clear start");
        step(1, 1, 0, 0, "R3 stop");
        step(1, 1, 0, 1, "R5 clear stop");
        irq_en = 2'b00;
        step(1, 0, 0, 0, "R7 masked start");
        irq_en = 2'b01;
        step(1, 0, 0, 0, "R7 start enabled");
        irq_en = 2'b10;
        step(1, 1, 1, 0, "R7 stop enabled");
        step(1, 0, 1, 0, "R5 set wins over clear");

        // R6 wiggles without enable
        @(negedge clk); sda_s = 1'b1;
        @(negedge clk); sda_s = 1'b0; scl_s = 1'b1;
        @(negedge clk); sda_s = 1'b1;
        @(negedge clk); sda_s = 1'b0;
        compare("R6 no effect without samp_en");
        step(1, 0, 1, 1, "R6 steady sample");

        // R8 hang boundary: 15 samples no hang, 16th hang
        step(0, 0, 0, 0, "R9 fall resets counter");
        for (int i = 1; i <= 15; i++) step(1, 0, 0, 0, "R8 counting");
        step(1, 0, 0, 0, "R8 hang at 16th");
        step(1, 0, 0, 0, "R8 hang holds");
        step(0, 0, 0, 0, "R9 hang cleared by fall");

        // R8 saturation with sda high, then sda low
        step(0, 1, 0, 0, "R6 setup");
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, "R8 saturate high");
        step(1, 0, 0, 0, "R8 hang after saturation");
        step(1, 1, 0, 0, "R9 hang cleared by stop");

        // R10 disable
        step(1, 0, 0, 0, "R2 start before disable");
        mon_off = 1'b1;
        step(1, 1, 0, 0, "R10 disabled");
        step(1, 0, 0, 0, "R10 start ignored while off");
        mon_off = 1'b0;
        step(1, 1, 0, 0, "R10 resumed");

        // pseudo-random sweep over all sample transitions
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (n % 64 == 0) irq_en = lf[10:9];
            mon_off = (lf[15:11] == 5'd0);
            step(lf[0], lf[1], lf[5:3] == 3'd0, lf[8:6] == 3'd0, "R2 R3 R5 R8 sweep");
        end
        mon_off = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule